// File: doc/BRIEF.md
# Emulation Shadow Register Access Router

This block sits behind a bus slave port and in front of a small bank of port replacement registers. Each register exists twice: an internal copy inside the chip and an external copy kept by emulator hardware. The router decides, from a single mode input, which copy a read comes from and which copies a write updates. It also turns the requested byte address and access size into a word index, a pair of byte-lane enables and lane-placed write data.

Every access takes exactly two bus cycles. The ready output stays low in the first cycle and goes high in the second, and read data is presented in the second cycle. Aligned word accesses and byte accesses do their register work in the first cycle. A read captures its data at the end of that cycle. A misaligned word access is split into two byte operations on adjacent word indices: the upper lane of the addressed word in the first cycle, and the lower lane of the following word in the second. Any bus master may use the port. The bus holds its request stable until ready is seen.

Top module: `shadow_route`

## Requirements
- R1: Every access asserted on `busSel` gives `busReady` low in its first cycle and high in its second cycle, for every access type and both modes. `busReady` is low while idle. The cycle after a ready cycle is the first cycle of the next access. `busRdata` is zero except in the second cycle of a read.
- R2: With `emuMode` = 1, a write drives `intWr` and `extWr` in the same cycles, with the same address, lanes and data, so both copies get identical contents.
- R3: With `emuMode` = 0, `extWr` stays low for every access and only the internal copy is written.
- R4: With `emuMode` = 1, reads pulse `extRd` only, and `busRdata` returns the external copy's data; `intRd` stays low.
- R5: With `emuMode` = 0, reads pulse `intRd` only, and `busRdata` returns the internal copy's data; `extRd` stays low.
- R6: A word access (`busWide` = 1) at an even address A drives one strobe cycle, in the first cycle, with `regAddr` = A >> 1 and `regLaneEn` = 2'b11. Lane 0 is bits 7:0 and holds byte A; lane 1 is bits 15:8 and holds byte A+1. A write passes `busWdata` through unchanged, and a read returns the whole word.
- R7: A byte access (`busWide` = 0) drives one strobe cycle. It uses lane 0 (`regLaneEn` = 2'b01) at an even address and lane 1 (2'b10) at an odd address. A write places `busWdata[7:0]` on that lane. A read returns the addressed byte in `busRdata[7:0]`, with the upper byte zero.
- R8: A word access at an odd address A uses two strobe cycles. In the first cycle, `regAddr` = A >> 1, the lane is 1, and the lane carries `busWdata[7:0]`. In the second cycle, `regAddr` = (A >> 1) + 1, the lane is 0, and the lane carries `busWdata[15:8]`. A read returns {byte A+1, byte A}.
- R9: The second word index of a split access wraps to 0 when the first index is the last one in the bank.
- R10: No strobe (`intWr`, `intRd`, `extWr`, `extRd`) is active while `busSel` is low, nor in the second cycle of an aligned word or byte access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| emuMode | input | 1 | 1 = emulation routing, 0 = normal routing |
| busSel | input | 1 | Access request, held until ready |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWide | input | 1 | 1 = word access, 0 = byte access |
| busAddr | input | ADDR_W | Byte address within the bank |
| busWdata | input | 2*LANE_W | Write data; a byte write uses the low lane |
| busRdata | output | 2*LANE_W | Read data, valid in the second cycle |
| busReady | output | 1 | High in the second cycle of an access |
| regAddr | output | ADDR_W-1 | Word index presented to both register copies |
| regLaneEn | output | 2 | Byte-lane enables for the active strobe |
| regWdata | output | 2*LANE_W | Lane-placed write data |
| intWr | output | 1 | Internal copy write strobe |
| intRd | output | 1 | Internal copy read strobe |
| intRdata | input | 2*LANE_W | Internal copy read data, combinational on regAddr |
| extWr | output | 1 | External copy write strobe |
| extRd | output | 1 | External copy read strobe |
| extRdata | input | 2*LANE_W | External copy read data, combinational on regAddr |

## Verification
Strobes, word index, lanes and write data for the first cycle follow the request combinationally, so they are due in the same cycle the request appears. Writes land at the first rising edge. Ready and read data are due one edge after the request. The second half of a split write lands at the second edge. The bench drives requests on the falling edge and checks the first-cycle ready level 1 ns later. It checks ready and read data at the next falling edge, after exactly one rising edge, and compares the register copies and strobe counts only once the access has finished.

// File: rtl/shadow_route_pkg.sv
package shadow_route_pkg;

  typedef enum logic [1:0] {
    ACC_WORD    = 2'd0,
    ACC_BYTE_LO = 2'd1,
    ACC_BYTE_HI = 2'd2,
    ACC_SPLIT   = 2'd3
  } acc_kind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic [1:0] laneEn;
    logic       nextWord;
    logic       capture;
    logic       dataValid;
    acc_kind_e  kind;
  } ctl_strobe_t;

endpackage

// File: rtl/shadow_route_decode.sv
module shadow_route_decode
  import shadow_route_pkg::*;
(
  input  logic      wide,
  input  logic      oddAddr,
  output acc_kind_e kind
);

  always_comb begin
    unique case ({wide, oddAddr})
      2'b10:   kind = ACC_WORD;
      2'b11:   kind = ACC_SPLIT;
      2'b01:   kind = ACC_BYTE_HI;
      default: kind = ACC_BYTE_LO;
    endcase
  end

endmodule

// File: rtl/shadow_route_ctrl.sv
module shadow_route_ctrl
  import shadow_route_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        emuMode,
  input  logic        busSel,
  input  logic        busWrite,
  input  acc_kind_e   kind,
  output logic        busReady,
  output logic        intWr,
  output logic        intRd,
  output logic        extWr,
  output logic        extRd,
  output ctl_strobe_t ctl
);

  typedef enum logic {ST_FIRST = 1'b0, ST_SECOND = 1'b1} phase_e;

  phase_e state, stateNext;
  logic   firstCyc, secondCyc, active, rdStb, wrStb;

  always_comb begin
    stateNext = ST_FIRST;
    if (state == ST_FIRST && busSel) stateNext = ST_SECOND;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_FIRST;
    else       state <= stateNext;
  end

  assign firstCyc  = busSel && (state == ST_FIRST);
  assign secondCyc = (state == ST_SECOND);
  assign active    = firstCyc || (secondCyc && kind == ACC_SPLIT);
  assign rdStb     = active && !busWrite;
  assign wrStb     = active && busWrite;

  // Mode routing of strobes
  assign intWr = wrStb;
  assign extWr = wrStb && emuMode;
  assign intRd = rdStb && !emuMode;
  assign extRd = rdStb && emuMode;

  assign busReady = secondCyc;

  always_comb begin
    ctl.laneEn = 2'b00;
    if (firstCyc) begin
      unique case (kind)
        ACC_WORD:    ctl.laneEn = 2'b11;
        ACC_BYTE_LO: ctl.laneEn = 2'b01;
        default:     ctl.laneEn = 2'b10;
      endcase
    end else if (secondCyc && kind == ACC_SPLIT) begin
      ctl.laneEn = 2'b01;
    end
    ctl.nextWord  = secondCyc;
    ctl.capture   = firstCyc && !busWrite;
    ctl.dataValid = secondCyc && !busWrite;
    ctl.kind      = kind;
  end

endmodule

// File: rtl/shadow_route_dpath.sv
module shadow_route_dpath
  import shadow_route_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8,
  localparam int WIDX_W = ADDR_W - 1,
  localparam int DATA_W = 2 * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              emuMode,
  input  logic [WIDX_W-1:0] wordIdx,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] intRdata,
  input  logic [DATA_W-1:0] extRdata,
  input  ctl_strobe_t       ctl,
  output logic [WIDX_W-1:0] regAddr,
  output logic [1:0]        regLaneEn,
  output logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] busRdata
);

  logic [DATA_W-1:0] rdSrc, holdData, rdAsm;
  logic [LANE_W-1:0] lowIn, highIn;

  assign lowIn  = busWdata[LANE_W-1:0];
  assign highIn = busWdata[DATA_W-1:LANE_W];

  // Second half of a split access targets the next index (wraps)
  assign regAddr   = ctl.nextWord ? WIDX_W'(wordIdx + 1'b1) : wordIdx;
  assign regLaneEn = ctl.laneEn;

  always_comb begin
    unique case (ctl.kind)
      ACC_WORD:  regWdata = busWdata;
      ACC_SPLIT: regWdata = {lowIn, highIn};
      default:   regWdata = {lowIn, lowIn};
    endcase
  end

  assign rdSrc = emuMode ? extRdata : intRdata;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            holdData <= '0;
    else if (ctl.capture) holdData <= rdSrc;
  end

  always_comb begin
    unique case (ctl.kind)
      ACC_WORD:    rdAsm = holdData;
      ACC_BYTE_LO: rdAsm = {{LANE_W{1'b0}}, holdData[LANE_W-1:0]};
      ACC_BYTE_HI: rdAsm = {{LANE_W{1'b0}}, holdData[DATA_W-1:LANE_W]};
      default:     rdAsm = {rdSrc[LANE_W-1:0], holdData[DATA_W-1:LANE_W]};
    endcase
  end

  assign busRdata = ctl.dataValid ? rdAsm : '0;

endmodule

// File: rtl/shadow_route.sv
module shadow_route
  import shadow_route_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  emuMode,
  input  logic                  busSel,
  input  logic                  busWrite,
  input  logic                  busWide,
  input  logic [ADDR_W-1:0]     busAddr,
  input  logic [2*LANE_W-1:0]   busWdata,
  output logic [2*LANE_W-1:0]   busRdata,
  output logic                  busReady,
  output logic [ADDR_W-2:0]     regAddr,
  output logic [1:0]            regLaneEn,
  output logic [2*LANE_W-1:0]   regWdata,
  output logic                  intWr,
  output logic                  intRd,
  input  logic [2*LANE_W-1:0]   intRdata,
  output logic                  extWr,
  output logic                  extRd,
  input  logic [2*LANE_W-1:0]   extRdata
);

  acc_kind_e   kind;
  ctl_strobe_t ctl;

  shadow_route_decode u_decode (
    .wide    (busWide),
    .oddAddr (busAddr[0]),
    .kind    (kind)
  );

  shadow_route_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .emuMode  (emuMode),
    .busSel   (busSel),
    .busWrite (busWrite),
    .kind     (kind),
    .busReady (busReady),
    .intWr    (intWr),
    .intRd    (intRd),
    .extWr    (extWr),
    .extRd    (extRd),
    .ctl      (ctl)
  );

  shadow_route_dpath #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .emuMode   (emuMode),
    .wordIdx   (busAddr[ADDR_W-1:1]),
    .busWdata  (busWdata),
    .intRdata  (intRdata),
    .extRdata  (extRdata),
    .ctl       (ctl),
    .regAddr   (regAddr),
    .regLaneEn (regLaneEn),
    .regWdata  (regWdata),
    .busRdata  (busRdata)
  );

endmodule

// File: rtl/shadow_route_chk.sv
module shadow_route_chk #(
  parameter int ADDR_W = 6,
  parameter int LANE_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                emuMode,
  input logic                busSel,
  input logic                busWrite,
  input logic                busWide,
  input logic [ADDR_W-1:0]   busAddr,
  input logic                busReady,
  input logic [1:0]          regLaneEn,
  input logic                intWr,
  input logic                intRd,
  input logic                extWr,
  input logic                extRd
);

  logic anyStb;
  assign anyStb = intWr || intRd || extWr || extRd;

  a_r1_ready_follows: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busReady |=> busReady);

  a_r1_ready_single: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  a_r2_ext_write_mirrored: assert property (@(posedge clk) disable iff (!rstN)
    extWr |-> intWr);

  a_r3_no_ext_write: assert property (@(posedge clk) disable iff (!rstN)
    !emuMode |-> !extWr);

  a_r4_emu_read_route: assert property (@(posedge clk) disable iff (!rstN)
    emuMode |-> !intRd);

  a_r5_normal_read_route: assert property (@(posedge clk) disable iff (!rstN)
    !emuMode |-> !extRd);

  a_r6_word_lanes: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busWide && !busAddr[0] && !busReady |-> regLaneEn == 2'b11);

  a_r8_split_second_lane: assert property (@(posedge clk) disable iff (!rstN)
    busSel && busWide && busAddr[0] && !busReady |=> !busSel || regLaneEn == 2'b01);

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> !anyStb);

  a_r10_second_quiet: assert property (@(posedge clk) disable iff (!rstN)
    busReady && !(busWide && busAddr[0]) |-> !anyStb);

  logic unusedWrite;
  assign unusedWrite = busWrite;

endmodule

bind shadow_route shadow_route_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .emuMode   (emuMode),
  .busSel    (busSel),
  .busWrite  (busWrite),
  .busWide   (busWide),
  .busAddr   (busAddr),
  .busReady  (busReady),
  .regLaneEn (regLaneEn),
  .intWr     (intWr),
  .intRd     (intRd),
  .extWr     (extWr),
  .extRd     (extRd)
);

// File: tb/shadow_route_bench.sv
`timescale 1ns/1ps
module shadow_route_bench;

  localparam int ADDR_W = 6;
  localparam int NW     = 1 << (ADDR_W - 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic emuMode = 1'b0, busSel = 1'b0, busWrite = 1'b0, busWide = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [15:0] busWdata = '0, busRdata, regWdata, intRdata, extRdata;
  logic busReady, intWr, intRd, extWr, extRd;
  logic [ADDR_W-2:0] regAddr;
  logic [1:0] regLaneEn;

  always #2.5 clk = ~clk;

  shadow_route #(.ADDR_W(ADDR_W), .LANE_W(8)) u_shadow_route (
    .clk(clk), .rstN(rstN), .emuMode(emuMode), .busSel(busSel),
    .busWrite(busWrite), .busWide(busWide), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .regAddr(regAddr), .regLaneEn(regLaneEn), .regWdata(regWdata),
    .intWr(intWr), .intRd(intRd), .intRdata(intRdata),
    .extWr(extWr), .extRd(extRd), .extRdata(extRdata)
  );

  // Two register copies around the router
  logic [15:0] intMem [NW];
  logic [15:0] extMem [NW];
  logic [15:0] expInt [NW];
  logic [15:0] expExt [NW];
  int nIntWr = 0, nIntRd = 0, nExtWr = 0, nExtRd = 0;

  assign intRdata = intMem[regAddr];
  assign extRdata = extMem[regAddr];

  always @(posedge clk) begin
    if (intWr) begin
      if (regLaneEn[0]) intMem[regAddr][7:0]  <= regWdata[7:0];
      if (regLaneEn[1]) intMem[regAddr][15:8] <= regWdata[15:8];
    end
    if (extWr) begin
      if (regLaneEn[0]) extMem[regAddr][7:0]  <= regWdata[7:0];
      if (regLaneEn[1]) extMem[regAddr][15:8] <= regWdata[15:8];
    end
    if (rstN) begin
      nIntWr <= nIntWr + int'(intWr);
      nIntRd <= nIntRd + int'(intRd);
      nExtWr <= nExtWr + int'(extWr);
      nExtRd <= nExtRd + int'(extRd);
    end
  end

  int tests = 0, fails = 0;
  bit done = 1'b0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // Expected-state model written from the requirements
  task automatic putByte(input bit toExt, input logic [4:0] w, input bit hi, input logic [7:0] b);
    if (toExt) begin
      if (hi) expExt[w][15:8] = b; else expExt[w][7:0] = b;
    end else begin
      if (hi) expInt[w][15:8] = b; else expInt[w][7:0] = b;
    end
  endtask

  task automatic modelWrite(input bit emu, input bit wide, input logic [5:0] a, input logic [15:0] d);
    for (int c = 0; c < 2; c++) begin
      if (c == 1 && !emu) continue;
      if (wide && !a[0]) begin
        putByte(c == 1, a[5:1], 1'b0, d[7:0]);
        putByte(c == 1, a[5:1], 1'b1, d[15:8]);
      end else if (!wide) begin
        putByte(c == 1, a[5:1], a[0], d[7:0]);
      end else begin
        putByte(c == 1, a[5:1], 1'b1, d[7:0]);
        putByte(c == 1, 5'(a[5:1] + 1), 1'b0, d[15:8]);
      end
    end
  endtask

  function automatic logic [15:0] modelRead(input bit emu, input bit wide, input logic [5:0] a);
    logic [15:0] w0, w1;
    w0 = emu ? expExt[a[5:1]] : expInt[a[5:1]];
    w1 = emu ? expExt[5'(a[5:1] + 1)] : expInt[5'(a[5:1] + 1)];
    if (wide && !a[0]) return w0;
    if (!wide) return {8'h00, a[0] ? w0[15:8] : w0[7:0]};
    return {w1[7:0], w0[15:8]};
  endfunction

  task automatic checkBanks(input string req);
    int bad = 0;
    for (int i = 0; i < NW; i++)
      if (intMem[i] !== expInt[i] || extMem[i] !== expExt[i]) bad++;
    chk({req, " register copies match model (mismatching words)"}, bad, 0);
  endtask

  // One access: checks ready timing (R1) and returns read data
  task automatic doAccess(input bit wr, input bit wide, input logic [5:0] a,
                          input logic [15:0] d, output logic [15:0] rd);
    @(negedge clk);
    busSel = 1'b1; busWrite = wr; busWide = wide; busAddr = a; busWdata = d;
    #1;
    chk("R1 ready low in first cycle", busReady, 0);
    @(negedge clk);
    chk("R1 ready high in second cycle", busReady, 1);
    rd = busRdata;
    @(posedge clk);
    #1 busSel = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ready low after reset", busReady, 0);
    chk("R1 rdata zero after reset", busRdata, 0);
    chk("R10 no strobes while idle", {intWr, intRd, extWr, extRd}, 0);
  endtask

  task automatic t_emu_word_write();
    logic [15:0] rd;
    int iw = nIntWr, ew = nExtWr;
    emuMode = 1'b1;
    doAccess(1'b1, 1'b1, 6'd4, 16'hA5C3, rd);
    modelWrite(1'b1, 1'b1, 6'd4, 16'hA5C3);
    checkBanks("R2 R6 emu word write");
    chk("R2 internal strobe cycles", nIntWr - iw, 1);
    chk("R2 external strobe cycles", nExtWr - ew, 1);
    chk("R1 rdata zero on write", rd, 0);
  endtask

  task automatic t_norm_word_write();
    logic [15:0] rd;
    int ew = nExtWr;
    emuMode = 1'b0;
    doAccess(1'b1, 1'b1, 6'd6, 16'h1234, rd);
    modelWrite(1'b0, 1'b1, 6'd6, 16'h1234);
    checkBanks("R3 normal word write");
    chk("R3 no external write strobe", nExtWr - ew, 0);
  endtask

  task automatic t_emu_read();
    logic [15:0] rd;
    int ir = nIntRd, er = nExtRd;
    emuMode = 1'b1;
    doAccess(1'b0, 1'b1, 6'd10, 16'h0, rd);
    chk("R4 emu read returns external copy", rd, modelRead(1'b1, 1'b1, 6'd10));
    chk("R4 no internal read strobe", nIntRd - ir, 0);
    chk("R6 one external read strobe cycle", nExtRd - er, 1);
  endtask

  task automatic t_norm_read();
    logic [15:0] rd;
    int ir = nIntRd, er = nExtRd;
    emuMode = 1'b0;
    doAccess(1'b0, 1'b1, 6'd10, 16'h0, rd);
    chk("R5 normal read returns internal copy", rd, modelRead(1'b0, 1'b1, 6'd10));
    chk("R5 no external read strobe", nExtRd - er, 0);
    chk("R10 single strobe cycle on word read", nIntRd - ir, 1);
  endtask

  task automatic t_bytes();
    logic [15:0] rd;
    emuMode = 1'b0;
    doAccess(1'b1, 1'b0, 6'd12, 16'hFF77, rd);
    modelWrite(1'b0, 1'b0, 6'd12, 16'hFF77);
    doAccess(1'b1, 1'b0, 6'd13, 16'hEE99, rd);
    modelWrite(1'b0, 1'b0, 6'd13, 16'hEE99);
    checkBanks("R7 byte writes");
    chk("R7 word 6 after byte writes", intMem[6], 16'h9977);
    doAccess(1'b0, 1'b0, 6'd13, 16'h0, rd);
    chk("R7 odd byte read", rd, 16'h0099);
    doAccess(1'b0, 1'b0, 6'd12, 16'h0, rd);
    chk("R7 even byte read", rd, 16'h0077);
  endtask

  task automatic t_split();
    logic [15:0] rd;
    int iw = nIntWr, ew = nExtWr;
    emuMode = 1'b1;
    doAccess(1'b1, 1'b1, 6'd9, 16'hBEEF, rd);
    modelWrite(1'b1, 1'b1, 6'd9, 16'hBEEF);
    checkBanks("R8 split write");
    chk("R8 ext word 4", extMem[4], 16'hEF04);
    chk("R8 ext word 5", extMem[5], 16'hE0BE);
    chk("R8 two internal strobe cycles", nIntWr - iw, 2);
    chk("R8 two external strobe cycles", nExtWr - ew, 2);
    doAccess(1'b0, 1'b1, 6'd9, 16'h0, rd);
    chk("R8 split read", rd, 16'hBEEF);
  endtask

  task automatic t_wrap();
    logic [15:0] rd;
    emuMode = 1'b0;
    doAccess(1'b0, 1'b1, 6'd63, 16'h0, rd);
    chk("R9 split read wraps to index 0", rd, modelRead(1'b0, 1'b1, 6'd63));
    doAccess(1'b1, 1'b1, 6'd63, 16'h5AC6, rd);
    modelWrite(1'b0, 1'b1, 6'd63, 16'h5AC6);
    checkBanks("R9 split write wraps");
    chk("R9 index 0 low lane", intMem[0][7:0], 8'h5A);
  endtask

  task automatic t_back_to_back();
    logic [15:0] rd;
    emuMode = 1'b1;
    doAccess(1'b0, 1'b0, 6'd1, 16'h0, rd);
    chk("R4 R7 byte read ext", rd, modelRead(1'b1, 1'b0, 6'd1));
    doAccess(1'b0, 1'b1, 6'd4, 16'h0, rd);
    chk("R1 second access in sequence", rd, modelRead(1'b1, 1'b1, 6'd4));
    @(negedge clk);
    chk("R1 ready low when idle", busReady, 0);
    chk("R10 idle strobes", {intWr, intRd, extWr, extRd}, 0);
  endtask

  initial begin
    for (int i = 0; i < NW; i++) begin
      intMem[i] = 16'h1000 + 16'(i);
      extMem[i] = 16'hE000 + 16'(i);
      expInt[i] = intMem[i];
      expExt[i] = extMem[i];
    end
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    t_emu_word_write();
    t_norm_word_write();
    t_emu_read();
    t_norm_read();
    t_bytes();
    t_split();
    t_wrap();
    t_back_to_back();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule